// File: doc/BRIEF.md
# Multi-Cycle 16-bit Load/Store Processor

This block is a small non-pipelined processor core. Each instruction walks through five clock cycles: fetch, decode, operand read, execute and write-back. Only then does the next fetch start. The core holds a program counter, an instruction register and eight general registers, each of data width. Every register resets to zero and every one of them is writable.

Instruction and data memories sit outside the block. Both are synchronous single-cycle read ports. The core presents an address, and the word comes back on the following cycle. Arithmetic and logic operate register to register. Only the load and store instructions touch data memory.

Control flow comes from three sources: the incremented PC, a relative unconditional jump, and a relative branch that is taken when two registers are equal. A one-cycle retire strobe marks the end of each instruction and carries its address. A halted flag goes high once a halt instruction completes. Both exist so that an environment can track progress.

Top module: `mc_cpu`

## Requirements
- R1: Reset (synchronous, active high) sets the PC and all eight registers to zero and puts the core in the fetch cycle. After reset, retire, halted and the data write strobe are low and the instruction address is zero.
- R2: Every instruction takes exactly five cycles.
  - Cycle 1 is fetch. The instruction address equals the PC, the returned word is captured, and the PC increments by one, modulo 2^PC_W.
  - Cycles 2 and 3 are decode and operand read.
  - Cycle 4 is execute.
  - Cycle 5 is write-back.
  - The PC changes only at the end of fetch or of execute.
- R3: The instruction word has four fields: opcode in bits 15:9, destination d in 8:6, source a in 5:3 and source b in 2:0. The register operations write R[d] as follows, wrapping modulo 2^DW:
  - 0x00: R[a]+R[b]
  - 0x01: R[a]-R[b]
  - 0x02: R[a]&R[b]
  - 0x03: R[a]|R[b]
  - 0x04: R[a]^R[b]
- R4: Opcode 0x05 writes R[d] = R[a] + c. Here c is bits 2:0, zero-extended.
- R5: Opcode 0x07 (store) raises the data write strobe for exactly one cycle, the execute cycle. The address is the low AW bits of R[a] and the data is R[b]. No other instruction raises the strobe.
- R6: Opcode 0x06 (load) writes R[d] with the data word at the low AW bits of R[a].
- R7: Opcode 0x08 compares R[a] with R[b].
  - If they are equal, the PC becomes the incremented PC plus the sign-extended 3-bit value in bits 8:6.
  - Otherwise the PC stays at the incremented value.
- R8: Opcode 0x09 sets the PC to the incremented PC plus the sign-extended 6-bit value {bits 8:6, bits 2:0}.
- R9: Opcode 0x7F retires normally. From the next cycle on, halted stays high, retire stays low, no data write occurs and the instruction address no longer changes.
- R10: Any other opcode changes no register, no memory location and nothing in the control flow. It still takes five cycles and retires.
- R11: Retire is high for one cycle, in write-back. Retire_pc then holds the address the instruction was fetched from, and the instruction address shows the PC of the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | PC_W | Instruction memory address (current PC) |
| imem_rdata | input | 16 | Instruction word, valid one cycle after its address |
| dmem_addr | output | AW | Data memory address |
| dmem_wdata | output | DW | Data memory write data |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | DW | Data memory read word, valid one cycle after its address |
| retire | output | 1 | One-cycle pulse when an instruction completes |
| retire_pc | output | PC_W | Address of the completing instruction |
| halted | output | 1 | High once a halt instruction has completed |

## Verification
The bench builds the core with DW=16, PC_W=7 and AW=6. This gives a 128-word program space and a 64-word data memory. With that size the bench can compare the entire data memory against its own model at the end of the run.

The 6-bit data address means a store through a register holding 0xFFFE lands at word 62. This makes the address truncation visible.

The program exercises several control-flow cases:
- a branch that falls through and one that is taken
- a forward jump over stores that must never happen
- a backward jump that closes a five-iteration countdown loop
- an undefined opcode whose fields would redirect a later store if it wrote a register

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

    localparam int IW = 16;

    localparam logic [6:0] OPC_ADD  = 7'h00;
    localparam logic [6:0] OPC_SUB  = 7'h01;
    localparam logic [6:0] OPC_AND  = 7'h02;
    localparam logic [6:0] OPC_OR   = 7'h03;
    localparam logic [6:0] OPC_XOR  = 7'h04;
    localparam logic [6:0] OPC_ADDI = 7'h05;
    localparam logic [6:0] OPC_LD   = 7'h06;
    localparam logic [6:0] OPC_ST   = 7'h07;
    localparam logic [6:0] OPC_BEQ  = 7'h08;
    localparam logic [6:0] OPC_JMP  = 7'h09;
    localparam logic [6:0] OPC_HALT = 7'h7F;

    typedef enum logic [2:0] {
        ST_IF, ST_ID, ST_OF, ST_EX, ST_WB, ST_HALT
    } cyc_state_e;

    typedef enum logic [3:0] {
        K_NOP, K_ADD, K_SUB, K_AND, K_OR, K_XOR,
        K_LD, K_ST, K_BEQ, K_JMP, K_HALT
    } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic        use_imm;
        logic        wr_en;
        logic [2:0]  rd;
        logic [2:0]  ra;
        logic [2:0]  rb;
        logic [5:0]  off;
    } dec_t;

    function automatic dec_t decode(input logic [IW-1:0] iw);
        dec_t d;
        d         = '0;
        d.kind    = K_NOP;
        d.rd      = iw[8:6];
        d.ra      = iw[5:3];
        d.rb      = iw[2:0];
        unique case (iw[15:9])
            OPC_ADD:  begin d.kind = K_ADD; d.wr_en = 1'b1; end
            OPC_SUB:  begin d.kind = K_SUB; d.wr_en = 1'b1; end
            OPC_AND:  begin d.kind = K_AND; d.wr_en = 1'b1; end
            OPC_OR:   begin d.kind = K_OR;  d.wr_en = 1'b1; end
            OPC_XOR:  begin d.kind = K_XOR; d.wr_en = 1'b1; end
            OPC_ADDI: begin d.kind = K_ADD; d.wr_en = 1'b1; d.use_imm = 1'b1; end
            OPC_LD:   begin d.kind = K_LD;  d.wr_en = 1'b1; end
            OPC_ST:   d.kind = K_ST;
            OPC_BEQ:  begin d.kind = K_BEQ; d.off = {{3{iw[8]}}, iw[8:6]}; end
            OPC_JMP:  begin d.kind = K_JMP; d.off = {iw[8:6], iw[2:0]}; end
            OPC_HALT: d.kind = K_HALT;
            default:  d.kind = K_NOP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 8,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [DW-1:0]  wd,
    input  logic [RAW-1:0] ra0,
    input  logic [RAW-1:0] ra1,
    output logic [DW-1:0]  rd0,
    output logic [DW-1:0]  rd1
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd0 = regs[ra0];
    assign rd1 = regs[ra1];
endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_kind_e       kind,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  y,
    output logic           eq
);
    always_comb begin
        unique case (kind)
            K_ADD:   y = a + b;
            K_SUB:   y = a - b;
            K_AND:   y = a & b;
            K_OR:    y = a | b;
            K_XOR:   y = a ^ b;
            default: y = '0;
        endcase
    end

    assign eq = (a == b);
endmodule

// File: rtl/mc_seq.sv
`timescale 1ns/1ps
module mc_seq
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_req,
    output cyc_state_e state
);
    cyc_state_e nxt;

    always_comb begin
        unique case (state)
            ST_IF:   nxt = ST_ID;
            ST_ID:   nxt = ST_OF;
            ST_OF:   nxt = ST_EX;
            ST_EX:   nxt = ST_WB;
            ST_WB:   nxt = halt_req ? ST_HALT : ST_IF;
            default: nxt = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IF;
        else     state <= nxt;
    end

    AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IF) |=> (state == ST_ID)); // R2
    AST_WB_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WB) |=> (state == ST_IF || state == ST_HALT)); // R2
endmodule

// File: rtl/mc_cpu.sv
`timescale 1ns/1ps
module mc_cpu
    import mc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int PC_W = 8,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PC_W-1:0] imem_addr,
    input  logic [15:0]     imem_rdata,
    output logic [AW-1:0]   dmem_addr,
    output logic [DW-1:0]   dmem_wdata,
    output logic            dmem_we,
    input  logic [DW-1:0]   dmem_rdata,
    output logic            retire,
    output logic [PC_W-1:0] retire_pc,
    output logic            halted
);
    localparam int NREG  = 8;
    localparam int OFF_W = 6;

    cyc_state_e      state;
    logic [PC_W-1:0] pc, ipc;
    logic [15:0]     ir;
    dec_t            dec_q;
    logic [DW-1:0]   opa, opb, res;
    logic [DW-1:0]   rf_rd0, rf_rd1, alu_y;
    logic            alu_eq;
    logic            rf_we;
    logic [DW-1:0]   rf_wd;
    logic [PC_W-1:0] pc_off;
    logic            redirect;

    mc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .halt_req (dec_q.kind == K_HALT),
        .state    (state)
    );

    mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk (clk),
        .rst (rst),
        .we  (rf_we),
        .wa  (dec_q.rd),
        .wd  (rf_wd),
        .ra0 (dec_q.ra),
        .ra1 (dec_q.rb),
        .rd0 (rf_rd0),
        .rd1 (rf_rd1)
    );

    mc_alu #(.DW(DW)) u_alu (
        .kind (dec_q.kind),
        .a    (opa),
        .b    (opb),
        .y    (alu_y),
        .eq   (alu_eq)
    );

    assign pc_off   = {{(PC_W-OFF_W){dec_q.off[OFF_W-1]}}, dec_q.off};
    assign redirect = (dec_q.kind == K_JMP) || (dec_q.kind == K_BEQ && alu_eq);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            ipc   <= '0;
            ir    <= '0;
            dec_q <= '0;
            opa   <= '0;
            opb   <= '0;
            res   <= '0;
        end else begin
            unique case (state)
                ST_IF: begin
                    ir  <= imem_rdata;
                    ipc <= pc;
                    pc  <= pc + PC_W'(1);
                end
                ST_ID: dec_q <= decode(ir);
                ST_OF: begin
                    opa <= rf_rd0;
                    opb <= dec_q.use_imm ? DW'(dec_q.rb) : rf_rd1;
                end
                ST_EX: begin
                    res <= alu_y;
                    if (redirect) pc <= pc + pc_off;
                end
                default: ;
            endcase
        end
    end

    assign rf_we      = (state == ST_WB) && dec_q.wr_en;
    assign rf_wd      = (dec_q.kind == K_LD) ? dmem_rdata : res;
    assign imem_addr  = pc;
    assign dmem_addr  = opa[AW-1:0];
    assign dmem_wdata = opb;
    assign dmem_we    = (state == ST_EX) && (dec_q.kind == K_ST);
    assign retire     = (state == ST_WB);
    assign retire_pc  = ipc;
    assign halted     = (state == ST_HALT);

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IF) |=> (pc == $past(pc) + PC_W'(1))); // R2
    AST_PC_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(state == ST_IF || state == ST_EX) |=> $stable(pc)); // R2
    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EX && dec_q.kind == K_BEQ && opa != opb) |=> $stable(pc)); // R7
    AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we); // R5
    AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        retire |=> !retire); // R11
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !retire && !dmem_we && $stable(imem_addr))); // R9
endmodule

// File: tb/mc_cpu_tb.sv
`timescale 1ns/1ps
module mc_cpu_tb;
    localparam int DW   = 16;
    localparam int PC_W = 7;
    localparam int AW   = 6;
    localparam int PCN  = 1 << PC_W;
    localparam int DN   = 1 << AW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] imem_addr;
    logic [15:0]     imem_rdata;
    logic [AW-1:0]   dmem_addr;
    logic [DW-1:0]   dmem_wdata;
    logic            dmem_we;
    logic [DW-1:0]   dmem_rdata;
    logic            retire;
    logic [PC_W-1:0] retire_pc;
    logic            halted;

    logic [15:0]     imem [PCN];
    logic [DW-1:0]   dmem [DN];

    logic [DW-1:0]   mr  [8];
    logic [DW-1:0]   mdm [DN];
    int mpc, mnext, exp_rpc, exp_addr, halt_addr;
    logic [DW-1:0] exp_data;
    bit exp_st, exp_halt, mhalt, done;
    int checks = 0, errors = 0, cyc, post;

    always #2.5 clk = ~clk;

    mc_cpu #(.DW(DW), .PC_W(PC_W), .AW(AW)) u_dut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata),
        .retire(retire), .retire_pc(retire_pc), .halted(halted)
    );

    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr];
        dmem_rdata <= dmem[dmem_addr];
        if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int d, input int a, input int b);
        return {op[6:0], d[2:0], a[2:0], b[2:0]};
    endfunction

    function automatic int wrap_pc(input int v);
        return ((v % PCN) + PCN) % PCN;
    endfunction

    task automatic model_step();
        logic [15:0] iw;
        logic [DW-1:0] va, vb;
        int op, d, a, b, npc, o;
        iw = imem[mpc];
        op = int'(iw[15:9]); d = int'(iw[8:6]); a = int'(iw[5:3]); b = int'(iw[2:0]);
        va = mr[a]; vb = mr[b];
        npc = wrap_pc(mpc + 1);
        exp_rpc = mpc; exp_st = 0; exp_halt = 0;
        case (op)
            0: mr[d] = va + vb;
            1: mr[d] = va - vb;
            2: mr[d] = va & vb;
            3: mr[d] = va | vb;
            4: mr[d] = va ^ vb;
            5: mr[d] = va + DW'(b);
            6: mr[d] = mdm[int'(va) % DN];
            7: begin
                exp_st = 1; exp_addr = int'(va) % DN; exp_data = vb;
                mdm[exp_addr] = vb;
            end
            8: if (va == vb) begin
                o = d; if (o >= 4) o -= 8;
                npc = wrap_pc(npc + o);
            end
            9: begin
                o = d * 8 + b; if (o >= 32) o -= 64;
                npc = wrap_pc(npc + o);
            end
            127: exp_halt = 1;
            default: ;
        endcase
        mnext = npc;
        mpc = npc;
    endtask

    initial begin
        for (int i = 0; i < PCN; i++) imem[i] = enc(7'h20, 0, 0, 0);
        for (int i = 0; i < DN; i++) begin
            dmem[i] = 16'hA000 + DW'(i);
            mdm[i]  = 16'hA000 + DW'(i);
        end
        for (int i = 0; i < 8; i++) mr[i] = '0;
        imem[0]  = enc(5, 1, 0, 5);       // ADDI r1=5
        imem[1]  = enc(5, 2, 0, 3);       // ADDI r2=3
        imem[2]  = enc(0, 3, 1, 2);       // ADD r3=8
        imem[3]  = enc(1, 4, 2, 1);       // SUB r4=FFFE
        imem[4]  = enc(2, 5, 3, 4);       // AND r5=8
        imem[5]  = enc(3, 6, 1, 2);       // OR r6=7
        imem[6]  = enc(4, 7, 1, 2);       // XOR r7=6
        imem[7]  = enc(7, 0, 0, 3);       // ST m[0]=8
        imem[8]  = enc(7, 0, 6, 7);       // ST m[7]=6
        imem[9]  = enc(7, 0, 5, 5);       // ST m[8]=8
        imem[10] = enc(7'h20, 1, 2, 2);   // undefined opcode
        imem[11] = enc(7, 0, 1, 4);       // ST m[5]=FFFE
        imem[12] = enc(6, 5, 1, 0);       // LD r5=m[5]
        imem[13] = enc(7, 0, 2, 5);       // ST m[3]=r5
        imem[14] = enc(8, 3, 1, 2);       // BEQ r1,r2 not taken
        imem[15] = enc(8, 2, 3, 3);       // BEQ taken -> 18
        imem[16] = enc(5, 1, 1, 1);       // skipped
        imem[17] = enc(5, 1, 1, 1);       // skipped
        imem[18] = enc(9, 0, 0, 3);       // JMP -> 22
        imem[19] = enc(7, 0, 0, 1);       // skipped stores
        imem[20] = enc(7, 0, 0, 1);
        imem[21] = enc(7, 0, 0, 1);
        imem[22] = enc(5, 7, 0, 1);       // r7=1
        imem[23] = enc(1, 1, 1, 7);       // r1--
        imem[24] = enc(8, 1, 1, 0);       // BEQ r1,r0 -> 26
        imem[25] = enc(9, 7, 0, 5);       // JMP -3 -> 23
        imem[26] = enc(5, 6, 6, 7);       // r6=14
        imem[27] = enc(6, 4, 6, 0);       // LD r4=m[14]
        imem[28] = enc(7, 0, 7, 4);       // ST m[1]=A00E
        imem[29] = enc(7, 0, 6, 6);       // ST m[14]=14
        imem[30] = enc(7, 0, 5, 7);       // ST m[62]=1
        imem[31] = enc(7'h7F, 0, 0, 0);   // HALT

        mpc = 0; mhalt = 0; done = 0; post = 0; cyc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(retire == 1'b0, "R1 retire after reset", int'(retire), 0);
        check(halted == 1'b0, "R1 halted after reset", int'(halted), 0);
        check(dmem_we == 1'b0, "R1 write strobe after reset", int'(dmem_we), 0);
        check(imem_addr == '0, "R1 fetch address after reset", int'(imem_addr), 0);

        while (!done) begin
            automatic int ph = cyc % 5;
            if (!mhalt) begin
                if (ph == 0) model_step();
                check(retire == (ph == 4), "R11 retire timing", int'(retire), int'(ph == 4));
                check(dmem_we == (ph == 3 && exp_st), "R5 write strobe", int'(dmem_we),
                      int'(ph == 3 && exp_st));
                check(halted == 1'b0, "R9 halted early", int'(halted), 0);
                if (ph == 3 && exp_st) begin
                    check(int'(dmem_addr) == exp_addr, "R5 store address", int'(dmem_addr), exp_addr);
                    check(dmem_wdata == exp_data, "R5 store data", int'(dmem_wdata), int'(exp_data));
                end
                if (ph == 4) begin
                    check(int'(retire_pc) == exp_rpc, "R11 retire pc", int'(retire_pc), exp_rpc);
                    check(int'(imem_addr) == mnext, "R2 R7 R8 next pc", int'(imem_addr), mnext);
                    if (exp_halt) begin
                        mhalt = 1;
                        halt_addr = mnext;
                    end
                end
            end else begin
                check(halted == 1'b1, "R9 halted held", int'(halted), 1);
                check(retire == 1'b0 && dmem_we == 1'b0, "R9 quiet after halt",
                      int'({retire, dmem_we}), 0);
                check(int'(imem_addr) == halt_addr, "R9 fetch frozen", int'(imem_addr), halt_addr);
                post++;
                if (post >= 10) done = 1;
            end
            cyc++;
            if (cyc > 3000) begin
                check(1'b0, "watchdog expired", cyc, 3000);
                done = 1;
            end
            @(negedge clk);
        end

        check(dmem[0] == 16'h0008, "R3 ADD result / R8 skipped stores", int'(dmem[0]), 16'h0008);
        check(dmem[7] == 16'h0006, "R3 XOR result at OR-formed address", int'(dmem[7]), 16'h0006);
        check(dmem[8] == 16'h0008, "R3 AND result", int'(dmem[8]), 16'h0008);
        check(dmem[5] == 16'hFFFE, "R3 SUB wrap / R10 undefined opcode kept r1", int'(dmem[5]), 16'hFFFE);
        check(dmem[6] == 16'hA006, "R10 no stray store", int'(dmem[6]), 16'hA006);
        check(dmem[3] == 16'hFFFE, "R6 load of stored word", int'(dmem[3]), 16'hFFFE);
        check(dmem[1] == 16'hA00E, "R6 load of preset word", int'(dmem[1]), 16'hA00E);
        check(dmem[14] == 16'h000E, "R4 immediate add / R7 loop exit", int'(dmem[14]), 16'h000E);
        check(dmem[62] == 16'h0001, "R5 address truncation", int'(dmem[62]), 16'h0001);
        for (int i = 0; i < DN; i++)
            if (dmem[i] != mdm[i])
                check(1'b0, "R5 R6 data memory image", int'(dmem[i]), int'(mdm[i]));
        checks++;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule